// File: doc/BRIEF.md
# Edge-Latched Secondary Interrupt Controller

This block collects up to 32 edge-triggered interrupt sources and presents them to a parent interrupt controller as one chained request line. Each source passes through a synchronizer; a rising transition (previous sample low, current sample high) records a pending event in the cause register. Events are recorded whether or not the source is enabled, so software sees stale events unless it clears them before it enables a source.

Software reaches two registers through a simple single-cycle register port. The cause register sits at byte offset 0x00 and is cleared by writing zeros: each bit written as 0 is cleared and each bit written as 1 keeps its value. The enable (mask) register sits at byte offset 0x04. A 1 in the mask lets the matching pending event drive the chained request. The request line is high whenever any bit is both pending and enabled.

Top module: `edge_irq_bridge`

## Requirements
- R1: Reads at byte offset 0x00 return the cause register, reads at 0x04 return the mask register, and reads at any other offset return zero.
- R2: A 0-to-1 transition on a source, after the synchronizer, sets its cause bit; a 1-to-0 transition or a level held high sets nothing.
- R3: A cause bit is set by a source edge even while that source's mask bit is 0.
- R4: A write to the cause register clears every bit written as 0 and leaves every bit written as 1 unchanged.
- R5: Writing the value zero to the cause register clears all pending events.
- R6: The chained request output is high exactly when some implemented bit is 1 in both the cause and mask registers; a mask bit of 1 enables its source.
- R7: Writing zero to the mask register drives the chained request low in the cycle after the write.
- R8: When a source edge and a cause write that would clear the same bit occur in the same cycle, the bit ends up set.
- R9: After reset the cause and mask registers read zero and the chained request is low.
- R10: Register bits at and above the source count read as zero and are not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| srcIn | input | NUM_SRC | Asynchronous interrupt source lines |
| regAddr | input | ADDR_W | Register byte offset |
| regWrEn | input | 1 | Write strobe, one cycle per write |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr, combinational |
| irqOut | output | 1 | Chained request to the parent controller |

## Verification
The bench builds the block with 20 sources and a two-stage synchronizer. The reduced source count leaves twelve unimplemented bits in each register, so writes of all ones can show that the upper bits are neither stored nor returned. The fixed synchronizer depth makes the edge-to-latch delay known exactly, so an edge and a clearing write can be placed in the same cycle to test the collision rule.

// File: rtl/bridge_irq_pkg.sv
package bridge_irq_pkg;
  localparam int CAUSE_OFS = 0;
  localparam int MASK_OFS  = 4;
  localparam int REG_W     = 32;

  typedef struct packed {
    logic causeWr;
    logic maskWr;
    logic causeRd;
    logic maskRd;
  } regStrobe_t;
endpackage

// File: rtl/bridge_irq_ctrl.sv
module bridge_irq_ctrl
  import bridge_irq_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output regStrobe_t        strobe
);
  localparam logic [ADDR_W-1:0] CAUSE_A = ADDR_W'(CAUSE_OFS);
  localparam logic [ADDR_W-1:0] MASK_A  = ADDR_W'(MASK_OFS);

  logic hitCause;
  logic hitMask;

  always_comb begin
    hitCause = (regAddr == CAUSE_A);
    hitMask  = (regAddr == MASK_A);
    strobe.causeWr = regWrEn && hitCause;
    strobe.maskWr  = regWrEn && hitMask;
    strobe.causeRd = hitCause;
    strobe.maskRd  = hitMask;
  end
endmodule

// File: rtl/bridge_irq_sync.sv
module bridge_irq_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stageQ [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stageQ[0] <= '0;
    else        stageQ[0] <= din;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stageQ[i] <= '0;
      else        stageQ[i] <= stageQ[i-1];
    end
  end

  assign dout = stageQ[STAGES-1];
endmodule

// File: rtl/bridge_irq_dp.sv
module bridge_irq_dp
  import bridge_irq_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] srcIn,
  input  regStrobe_t         strobe,
  input  logic [REG_W-1:0]   wrData,
  output logic [REG_W-1:0]   rdData,
  output logic               irqOut,
  output logic [NUM_SRC-1:0] causeQ,
  output logic [NUM_SRC-1:0] maskQ,
  output logic [NUM_SRC-1:0] edgeHit
);
  logic [NUM_SRC-1:0] srcSync;
  logic [NUM_SRC-1:0] prevQ;
  logic [NUM_SRC-1:0] keepBits;
  logic [NUM_SRC-1:0] wrSlice;

  bridge_irq_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (srcIn),
    .dout (srcSync)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prevQ <= '0;
    else        prevQ <= srcSync;
  end

  assign edgeHit = srcSync & ~prevQ;
  assign wrSlice = wrData[NUM_SRC-1:0];

  // Clearing write keeps only bits written as 1; a fresh edge always wins.
  always_comb begin
    keepBits = strobe.causeWr ? wrSlice : '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) causeQ <= '0;
    else        causeQ <= (causeQ & keepBits) | edgeHit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             maskQ <= '0;
    else if (strobe.maskWr) maskQ <= wrSlice;
  end

  always_comb begin
    rdData = '0;
    if (strobe.causeRd)     rdData[NUM_SRC-1:0] = causeQ;
    else if (strobe.maskRd) rdData[NUM_SRC-1:0] = maskQ;
  end

  assign irqOut = |(causeQ & maskQ);
endmodule

// File: rtl/edge_irq_bridge.sv
module edge_irq_bridge
  import bridge_irq_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic [31:0]        regWrData,
  output logic [31:0]        regRdData,
  output logic               irqOut
);
  regStrobe_t         strobe;
  logic [NUM_SRC-1:0] causeVec;
  logic [NUM_SRC-1:0] maskVec;
  logic [NUM_SRC-1:0] edgeVec;

  bridge_irq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regAddr(regAddr),
    .regWrEn(regWrEn),
    .strobe (strobe)
  );

  bridge_irq_dp #(.NUM_SRC(NUM_SRC), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .srcIn  (srcIn),
    .strobe (strobe),
    .wrData (regWrData),
    .rdData (regRdData),
    .irqOut (irqOut),
    .causeQ (causeVec),
    .maskQ  (maskVec),
    .edgeHit(edgeVec)
  );
endmodule

// File: rtl/edge_irq_bridge_chk.sv
module edge_irq_bridge_chk #(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  regAddr,
  input logic               regWrEn,
  input logic [31:0]        regWrData,
  input logic [31:0]        regRdData,
  input logic               irqOut,
  input logic [NUM_SRC-1:0] causeVec,
  input logic [NUM_SRC-1:0] edgeVec
);
  logic causeWrite;
  logic maskWrite;
  logic [NUM_SRC-1:0] wrBits;

  assign causeWrite = regWrEn && (regAddr == ADDR_W'(0));
  assign maskWrite  = regWrEn && (regAddr == ADDR_W'(4));
  assign wrBits     = regWrData[NUM_SRC-1:0];

  AST_MASK_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (maskWrite && regWrData == '0) |=> !irqOut); // R7

  AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (edgeVec != '0) |=> ((causeVec & $past(edgeVec)) == $past(edgeVec))); // R3

  AST_W0C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    causeWrite |=> ((causeVec & ~$past(wrBits) & ~$past(edgeVec)) == '0)); // R4

  AST_W1_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    causeWrite |=> (($past(causeVec) & $past(wrBits) & ~causeVec) == '0)); // R4

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((causeVec & ~$past(causeVec) & ~$past(edgeVec)) == '0)); // R2

  AST_COLLIDE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (causeWrite && ((edgeVec & ~wrBits) != '0)) |=>
      ((causeVec & $past(edgeVec)) == $past(edgeVec))); // R8

  if (NUM_SRC < 32) begin : g_upper
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      regRdData[31:NUM_SRC] == '0); // R10
  end
endmodule

bind edge_irq_bridge edge_irq_bridge_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .regAddr  (regAddr),
  .regWrEn  (regWrEn),
  .regWrData(regWrData),
  .regRdData(regRdData),
  .irqOut   (irqOut),
  .causeVec (causeVec),
  .edgeVec  (edgeVec)
);

// File: tb/edge_irq_bridge_test.sv
module edge_irq_bridge_test;
  localparam int NSRC = 20;
  localparam int AW   = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] srcIn = '0;
  logic [AW-1:0]   regAddr = '0;
  logic            regWrEn = 1'b0;
  logic [31:0]     regWrData = '0;
  logic [31:0]     regRdData;
  logic            irqOut;

  int nRun = 0;
  int nFail = 0;

  edge_irq_bridge #(.NUM_SRC(NSRC), .ADDR_W(AW), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .srcIn(srcIn), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .irqOut(irqOut)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input int b);
    @(negedge clk); srcIn[b] = 1'b1;
    idle(4);
    srcIn[b] = 1'b0;
    idle(4);
  endtask

  task automatic tReset;
    logic [31:0] v;
    rdReg(4'h0, v); check(v == 0, "R9 cause after reset", v, 0);
    rdReg(4'h4, v); check(v == 0, "R9 mask after reset", v, 0);
    check(irqOut == 1'b0, "R9 irq after reset", {31'b0, irqOut}, 0);
  endtask

  task automatic tRegMap;
    logic [31:0] v;
    wrReg(4'h4, 32'h0000_0A5A);
    rdReg(4'h4, v); check(v == 32'h0A5A, "R1 mask readback", v, 32'h0A5A);
    rdReg(4'h8, v); check(v == 0, "R1 unmapped offset 0x8", v, 0);
    rdReg(4'hC, v); check(v == 0, "R1 unmapped offset 0xC", v, 0);
    wrReg(4'h4, 32'h0);
  endtask

  task automatic tUpper;
    logic [31:0] v;
    wrReg(4'h4, 32'hFFFF_FFFF);
    rdReg(4'h4, v); check(v == 32'h000F_FFFF, "R10 mask upper bits", v, 32'h000F_FFFF);
    wrReg(4'h4, 32'h0);
  endtask

  task automatic tLatchMasked;
    logic [31:0] v;
    pulse(7);
    rdReg(4'h0, v); check(v == 32'h80, "R3 latch while masked", v, 32'h80);
    check(irqOut == 1'b0, "R6 masked pending keeps irq low", {31'b0, irqOut}, 0);
    pulse(19);
    rdReg(4'h0, v); check(v == 32'h8_0080, "R2 rising edge top source", v, 32'h8_0080);
  endtask

  task automatic tW0C;
    logic [31:0] v;
    wrReg(4'h0, ~32'h80);
    rdReg(4'h0, v); check(v == 32'h8_0000, "R4 zero bit clears, one keeps", v, 32'h8_0000);
    wrReg(4'h0, 32'h0);
    rdReg(4'h0, v); check(v == 0, "R5 write zero clears all", v, 0);
  endtask

  task automatic tLevels;
    logic [31:0] v;
    @(negedge clk); srcIn[4] = 1'b1;
    idle(4);
    wrReg(4'h0, 32'h0);
    idle(4);
    rdReg(4'h0, v); check(v == 0, "R2 held level does not relatch", v, 0);
    srcIn[4] = 1'b0;
    idle(4);
    rdReg(4'h0, v); check(v == 0, "R2 falling edge sets nothing", v, 0);
  endtask

  task automatic tIrq;
    logic [31:0] v;
    wrReg(4'h4, 32'h4);
    pulse(9);
    check(irqOut == 1'b0, "R6 other source masked", {31'b0, irqOut}, 0);
    pulse(2);
    check(irqOut == 1'b1, "R6 enabled pending raises irq", {31'b0, irqOut}, 1);
    wrReg(4'h0, ~32'h4);
    check(irqOut == 1'b0, "R6 clear enabled bit drops irq", {31'b0, irqOut}, 0);
    wrReg(4'h4, 32'h200);
    check(irqOut == 1'b1, "R6 enabling stale event raises irq", {31'b0, irqOut}, 1);
    @(negedge clk);
    regAddr = 4'h4; regWrData = 32'h0; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    check(irqOut == 1'b0, "R7 mask zero drops irq next cycle", {31'b0, irqOut}, 0);
    wrReg(4'h0, 32'h0);
  endtask

  task automatic tCollide;
    logic [31:0] v;
    pulse(3);
    @(negedge clk); srcIn[5] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    regAddr = 4'h0; regWrData = 32'h0; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    rdReg(4'h0, v); check(v == 32'h20, "R8 edge wins over clear", v, 32'h20);
    srcIn[5] = 1'b0;
    idle(4);
    wrReg(4'h0, 32'h0);
  endtask

  initial begin
    #(8 * 150000);
    nFail++;
    $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd1, 32'd0);
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    tReset();
    tRegMap();
    tUpper();
    tLatchMasked();
    tW0C();
    tLevels();
    tIrq();
    tCollide();
    idle(2);
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule